// File: doc/BRIEF.md
# Per-Processor User Timer Mode Controller

This block sits beside a bank of limit-mode counter-timers, one per processor, and lets software turn any of those timers into a free-running 63-bit user timer. A configuration register in the system timer's register space holds one mode bit per processor. While a processor's bit is set, that timer's two count registers become the upper and lower halves of a 63-bit count. The count moves in steps of 512 (bit 9 and up). Software starts and stops it with bit 0 of the timer's status word, and the timer's interrupt line is held low.

The limit-mode counting logic is outside this block; its interrupt requests come in on `lim_irq_i` and are gated here. Register access is a single-beat bus. A request is valid for the one cycle `bus_en` is high and is always accepted, so there is no back-pressure. A read answers with a one-cycle `rd_valid` pulse in the next cycle. `bus_sys` selects the system timer space; otherwise `bus_cpu` selects a processor timer. `bus_idx` is the word index.

Top module: `utm_user_timer_ctrl`

## Requirements
- R1: A write to word 4 of the system timer loads the mode register from write-data bits below NCPU. Higher data bits are dropped. A read of system word 4 returns the mode bits with all higher bits zero.
- R2: When a mode bit goes 0→1, that processor's running bit clears on the same clock edge as the mode bit changes.
- R3: When a mode bit goes 1→0, that processor's running bit sets on the same edge, because counter mode always runs.
- R4: In user mode, a read of processor word 0 returns the reached flag in bit 31 and count bits 62..32 in bits 30..0.
- R5: In user mode, a read of processor word 1 returns count bits 31..9 in bits 31..9, with bits 8..0 zero.
- R6: In user mode, a write to word 0 loads count bits 62..32 from data bits 30..0. A write to word 1 loads count bits 31..9 from data bits 31..9. Either write clears the reached flag and leaves the other half unchanged.
- R7: In user mode, a write to processor word 3 sets the running bit to data bit 0. A read of word 3 returns the running bit in bit 0 in any mode.
- R8: `cpu_irq_o[i]` follows `lim_irq_i[i]` in counter mode and is 0 whenever processor i is in user mode.
- R9: These writes are ignored: word 4 addressed to a processor timer, and words 0, 1 and 3 of a processor timer that is in counter mode.
- R10: In user mode with the running bit set, each cycle with `tick_en` high adds 512 to the count. In a cycle that also carries a word write, the write wins and no step is taken.
- R11: A step that would bring the count to 0x7FFFFFFFFFFFFE00 sets the count to zero and sets the reached flag.
- R12: `rd_valid` is high exactly in the cycle after a read request, with `rd_data` valid in that cycle. In counter mode, words 0 and 1 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: all processors in counter mode and running, counts and reached flags zero |
| tick_en | input | 1 | One count step per cycle when high |
| bus_en | input | 1 | Register request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sys | input | 1 | 1 = system timer space, 0 = processor timer space |
| bus_cpu | input | CPU_W | Processor timer index |
| bus_idx | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| lim_irq_i | input | NCPU | Interrupt requests from the limit-mode counters |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data |
| user_mode_o | output | NCPU | Current mode bits (1 = user timer) |
| run_o | output | NCPU | Current running bits |
| cpu_irq_o | output | NCPU | Gated processor interrupts |

## Verification
A count step and a word load can land on the same clock edge. The bench provokes this by raising `tick_en` in the cycle that carries a low-word write to a running user timer. It judges the outcome by reading back both halves: the low half must hold exactly the loaded value and the high half must be unchanged. One further tick must then add exactly 512. The second pair of coinciding events is a mode change in the cycle that would otherwise start the timer. This is judged from `run_o` after the edge across a full sweep of configuration values.

// File: rtl/utm_pkg.sv
package utm_pkg;
  localparam int CNT_BITS = 63;
  localparam int FRAC     = 9;
  localparam int PER_W    = CNT_BITS - FRAC;   // count held in 512-units
  localparam int HI_W     = CNT_BITS - 32;     // upper word field width
  localparam int LO_PW    = 32 - FRAC;         // lower word period bits

  typedef enum logic [2:0] {
    W_HI   = 3'd0,
    W_LO   = 3'd1,
    W_RSV  = 3'd2,
    W_STAT = 3'd3,
    W_CFG  = 3'd4
  } widx_e;

  typedef struct packed {
    logic        to_user;
    logic        to_cnt;
    logic        wr_hi;
    logic        wr_lo;
    logic        wr_stat;
    logic [31:0] data;
  } slot_cmd_t;
endpackage

// File: rtl/utm_cfg_reg.sv
module utm_cfg_reg #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NCPU-1:0] wdata,
  output logic [NCPU-1:0] mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_en) mode_q <= wdata;
  end

  // R1
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mode_q == $past(wdata)));
endmodule

// File: rtl/utm_slot.sv
module utm_slot
  import utm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_i,
  input  logic        tick_i,
  input  slot_cmd_t   cmd,
  input  logic        lim_irq_i,
  output logic        run_o,
  output logic [31:0] hi_o,
  output logic [31:0] lo_o,
  output logic        irq_o
);
  localparam logic [PER_W-1:0] LAST = {PER_W{1'b1}} - PER_W'(1);

  logic [PER_W-1:0] cnt_q;
  logic             reached_q;
  logic             run_q;
  logic             ld_hi, ld_lo, step;

  assign ld_hi = mode_i & cmd.wr_hi;
  assign ld_lo = mode_i & cmd.wr_lo;
  assign step  = mode_i & run_q & tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b1;
    end else if (cmd.to_user) begin
      run_q <= 1'b0;
    end else if (cmd.to_cnt) begin
      run_q <= 1'b1;
    end else if (mode_i && cmd.wr_stat) begin
      run_q <= cmd.data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      reached_q <= 1'b0;
    end else if (ld_hi) begin
      cnt_q[PER_W-1:LO_PW] <= cmd.data[HI_W-1:0];
      reached_q            <= 1'b0;
    end else if (ld_lo) begin
      cnt_q[LO_PW-1:0] <= cmd.data[31:FRAC];
      reached_q        <= 1'b0;
    end else if (step) begin
      if (cnt_q >= LAST) begin
        cnt_q     <= '0;
        reached_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + PER_W'(1);
      end
    end
  end

  assign run_o = run_q;
  assign hi_o  = {reached_q, cnt_q[PER_W-1:LO_PW]};
  assign lo_o  = {cnt_q[LO_PW-1:0], {FRAC{1'b0}}};
  assign irq_o = lim_irq_i & ~mode_i;

  // R2
  user_entry_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_i) |-> !run_q);
  // R3
  cnt_entry_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_i) |-> run_q);
  // R11
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reached_q) |-> (cnt_q == '0));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hi || ld_lo || step) |=> $stable(cnt_q));
endmodule

// File: rtl/utm_rd_port.sv
module utm_rd_port
  import utm_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  wr,
  input  logic                  sys,
  input  logic [CPU_W-1:0]      cpu,
  input  logic [2:0]            idx,
  input  logic [NCPU-1:0][31:0] hi_arr,
  input  logic [NCPU-1:0][31:0] lo_arr,
  input  logic [NCPU-1:0]       run,
  input  logic [NCPU-1:0]       mode,
  output logic                  rd_valid,
  output logic [31:0]           rd_data
);
  logic [31:0] sel;

  always_comb begin
    sel = '0;
    if (sys) begin
      if (idx == W_CFG) sel = 32'(mode);
    end else begin
      for (int k = 0; k < NCPU; k++) begin
        if (cpu == CPU_W'(k)) begin
          case (idx)
            W_HI:    sel = mode[k] ? hi_arr[k] : 32'd0;
            W_LO:    sel = mode[k] ? lo_arr[k] : 32'd0;
            W_STAT:  sel = {31'd0, run[k]};
            default: sel = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= en & ~wr;
      if (en && !wr) rd_data <= sel;
    end
  end

  // R12
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(en && !wr));
endmodule

// File: rtl/utm_user_timer_ctrl.sv
module utm_user_timer_ctrl
  import utm_pkg::*;
#(
  parameter int NCPU = 4,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic             bus_sys,
  input  logic [CPU_W-1:0] bus_cpu,
  input  logic [2:0]       bus_idx,
  input  logic [31:0]      bus_wdata,
  input  logic [NCPU-1:0]  lim_irq_i,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  output logic [NCPU-1:0]  user_mode_o,
  output logic [NCPU-1:0]  run_o,
  output logic [NCPU-1:0]  cpu_irq_o
);
  logic                  is_wr, cfg_wr;
  logic [NCPU-1:0]       mode;
  logic [NCPU-1:0][31:0] hi_arr, lo_arr;

  assign is_wr  = bus_en & bus_wr;
  assign cfg_wr = is_wr & bus_sys & (bus_idx == W_CFG);

  utm_cfg_reg #(.NCPU(NCPU)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr),
    .wdata  (bus_wdata[NCPU-1:0]),
    .mode_q (mode)
  );

  for (genvar i = 0; i < NCPU; i++) begin : g_slot
    slot_cmd_t cmd;
    logic      hit;
    assign hit         = is_wr & ~bus_sys & (bus_cpu == CPU_W'(i));
    assign cmd.to_user = cfg_wr & bus_wdata[i] & ~mode[i];
    assign cmd.to_cnt  = cfg_wr & ~bus_wdata[i] & mode[i];
    assign cmd.wr_hi   = hit & (bus_idx == W_HI);
    assign cmd.wr_lo   = hit & (bus_idx == W_LO);
    assign cmd.wr_stat = hit & (bus_idx == W_STAT);
    assign cmd.data    = bus_wdata;

    utm_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode[i]),
      .tick_i    (tick_en),
      .cmd       (cmd),
      .lim_irq_i (lim_irq_i[i]),
      .run_o     (run_o[i]),
      .hi_o      (hi_arr[i]),
      .lo_o      (lo_arr[i]),
      .irq_o     (cpu_irq_o[i])
    );
  end

  utm_rd_port #(.NCPU(NCPU), .CPU_W(CPU_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (bus_en),
    .wr       (bus_wr),
    .sys      (bus_sys),
    .cpu      (bus_cpu),
    .idx      (bus_idx),
    .hi_arr   (hi_arr),
    .lo_arr   (lo_arr),
    .run      (run_o),
    .mode     (mode),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign user_mode_o = mode;

  // R9
  cfg_foreign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && !bus_sys) |=> $stable(mode));
endmodule

// File: tb/utm_user_timer_ctrl_bench.sv
module utm_user_timer_ctrl_bench;
  localparam int NCPU  = 3;
  localparam int CPU_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick_en = 1'b0;
  logic             bus_en = 1'b0, bus_wr = 1'b0, bus_sys = 1'b0;
  logic [CPU_W-1:0] bus_cpu = '0;
  logic [2:0]       bus_idx = '0;
  logic [31:0]      bus_wdata = '0;
  logic [NCPU-1:0]  lim_irq_i = '0;
  logic             rd_valid;
  logic [31:0]      rd_data;
  logic [NCPU-1:0]  user_mode_o, run_o, cpu_irq_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  utm_user_timer_ctrl #(.NCPU(NCPU)) u_utm_user_timer_ctrl (
    .clk, .rst_n, .tick_en, .bus_en, .bus_wr, .bus_sys, .bus_cpu, .bus_idx,
    .bus_wdata, .lim_irq_i, .rd_valid, .rd_data, .user_mode_o, .run_o, .cpu_irq_o
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sys, input int cpu, input logic [2:0] idx, input logic [31:0] d);
    bus_en = 1; bus_wr = 1; bus_sys = sys; bus_cpu = CPU_W'(cpu); bus_idx = idx; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic sys, input int cpu, input logic [2:0] idx, output logic [31:0] q);
    bus_en = 1; bus_wr = 0; bus_sys = sys; bus_cpu = CPU_W'(cpu); bus_idx = idx;
    @(negedge clk);
    bus_en = 0;
    chk("R12 rd_valid", 64'(rd_valid), 64'd1);
    q = rd_data;
  endtask

  task automatic ticks(input int n);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  logic [31:0] q;
  logic [53:0] p;
  logic [31:0] h;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R1 reset mode", 64'(user_mode_o), 64'd0);
    chk("R3 reset run", 64'(run_o), 64'h7);
    chk("R12 reset rd_valid", 64'(rd_valid), 64'd0);
    lim_irq_i = 3'b111;
    #1;
    chk("R8 counter irq pass", 64'(cpu_irq_o), 64'h7);

    // sweep of every configuration pattern including the dropped bit 3
    for (int v = 0; v < 16; v++) begin
      wr(1, 0, 3'd4, 32'(v) | 32'hFFFF_FFF0 & 32'h0000_0000);
      chk("R1 mode", 64'(user_mode_o), 64'(v & 7));
      chk("R2 R3 run", 64'(run_o), 64'(~v & 7));
      chk("R8 irq gate", 64'(cpu_irq_o), 64'(~v & 7));
      rd(1, 0, 3'd4, q);
      chk("R1 cfg read", 64'(q), 64'(v & 7));
    end
    wr(1, 0, 3'd4, 32'hFFFF_FFF5);
    rd(1, 0, 3'd4, q);
    chk("R1 upper bits dropped", 64'(q), 64'd5);
    wr(0, 1, 3'd4, 32'h2);
    rd(1, 0, 3'd4, q);
    chk("R9 cfg via cpu ignored", 64'(q), 64'd5);
    wr(1, 0, 3'd4, 32'h0);

    for (int c = 0; c < NCPU; c++) begin
      // counter mode: word writes ignored
      wr(0, c, 3'd1, 32'h1234_5600);
      wr(0, c, 3'd0, 32'h0000_0077);
      wr(0, c, 3'd3, 32'h0);
      chk("R9 stat ignored run", 64'(run_o[c]), 64'd1);
      rd(0, c, 3'd1, q);
      chk("R12 counter lo reads 0", 64'(q), 64'd0);
      rd(0, c, 3'd3, q);
      chk("R7 stat read counter", 64'(q), 64'd1);

      wr(1, 0, 3'd4, 32'(1 << c));
      chk("R2 stopped", 64'(run_o[c]), 64'd0);
      chk("R8 irq suppressed", 64'(cpu_irq_o[c]), 64'd0);
      rd(0, c, 3'd1, q);
      chk("R9 lo untouched", 64'(q), 64'd0);
      rd(0, c, 3'd0, q);
      chk("R9 hi untouched", 64'(q), 64'd0);

      h = 32'h1234_0000 + 32'(c);
      wr(0, c, 3'd0, h);
      wr(0, c, 3'd1, 32'hFFFF_FA00);
      p = {h[30:0], 23'h7FFFFD};
      rd(0, c, 3'd0, q);
      chk("R4 hi read", 64'(q), 64'({1'b0, p[53:23]}));
      rd(0, c, 3'd1, q);
      chk("R5 lo read", 64'(q), 64'({p[22:0], 9'd0}));

      ticks(3);
      rd(0, c, 3'd1, q);
      chk("R10 stopped no step", 64'(q), 64'({p[22:0], 9'd0}));

      wr(0, c, 3'd3, 32'h1);
      rd(0, c, 3'd3, q);
      chk("R7 started", 64'(q), 64'd1);
      ticks(5);
      wr(0, c, 3'd3, 32'h0);
      chk("R7 stopped", 64'(run_o[c]), 64'd0);
      p = p + 54'd5;
      rd(0, c, 3'd0, q);
      chk("R10 hi after carry", 64'(q), 64'({1'b0, p[53:23]}));
      rd(0, c, 3'd1, q);
      chk("R10 lo after steps", 64'(q), 64'({p[22:0], 9'd0}));

      // tick coinciding with a low-word load
      wr(0, c, 3'd3, 32'h1);
      tick_en = 1;
      wr(0, c, 3'd1, 32'h0000_0400);
      tick_en = 0;
      rd(0, c, 3'd1, q);
      chk("R10 load wins", 64'(q), 64'h400);
      rd(0, c, 3'd0, q);
      chk("R6 hi kept", 64'(q), 64'({1'b0, p[53:23]}));
      ticks(1);
      rd(0, c, 3'd1, q);
      chk("R10 one step", 64'(q), 64'h600);
      wr(0, c, 3'd3, 32'h0);

      // wrap at the 63-bit limit
      wr(0, c, 3'd0, 32'h7FFF_FFFF);
      wr(0, c, 3'd1, 32'hFFFF_FC00);
      wr(0, c, 3'd3, 32'h1);
      ticks(1);
      wr(0, c, 3'd3, 32'h0);
      rd(0, c, 3'd0, q);
      chk("R11 reached hi", 64'(q), 64'h8000_0000);
      rd(0, c, 3'd1, q);
      chk("R11 lo zero", 64'(q), 64'd0);
      wr(0, c, 3'd0, 32'h0000_0005);
      rd(0, c, 3'd0, q);
      chk("R6 reached cleared", 64'(q), 64'h5);

      wr(1, 0, 3'd4, 32'h0);
      chk("R3 running again", 64'(run_o[c]), 64'd1);
      chk("R8 irq restored", 64'(cpu_irq_o[c]), 64'd1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule